// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a system watchdog on a 16-bit register bus. Once software enables it, a down-counter starts from a programmed timeout. The counter moves one step every half second, and the half second is derived from a slow low-frequency tick. Software keeps the system alive by writing an ordered two-word key to the service register. If it fails to do so, the block first raises an early-warning interrupt, when that is enabled and a lead time is programmed. When the count runs out, it raises either an internal chip-reset request or an active-low external reset line. The choice between the two is programmable.

Software can also request a chip reset directly, or drive the external reset line low. The block records whether the last reset cause was a timeout or a software request, and this record survives system resets. After every system reset, a boot-time power-down counter runs. If software does not disarm it, it pulses the external reset line low for one clock.

The enable and the timeout-action bits are sticky. The low-power suspend bit is accepted only on the first control write after reset.

Top module: `wdog_core`

## Requirements
- R1: After reset, control (offset 0x0) reads 0x0030, interrupt control (0x6) reads 0x0000, miscellaneous (0x8) reads 0x0001, reset status (0x4) reads 0x0000 after power-on, service (0x2) reads 0x0000; int_rst_o=0, ext_rst_no=1, irq_o=0.
- R2: Writing control with bit 2 = 1 starts the watchdog. The timeout code T is taken from bits 15:8 of the same write. With bit 3 = 0, int_rst_o rises (T+1)*PRESCALE clock cycles after the write edge and stays high until system reset. The counter then stops.
- R3: With control bit 3 = 1 at expiry, ext_rst_no goes low instead and int_rst_o stays low.
- R4: Writing 0x5555 to the service register and then 0xAAAA as the next service write reloads the count and restarts the half-second phase. Any other order, or any other value in between, leaves the countdown untouched.
- R5: Control bits 2 and 3 ignore writes of 0 once they are set.
- R6: Control bit 0 is taken only from the first control write after reset. While it is 1 and low_power_i is high, the countdown is frozen. With bit 0 = 0, low_power_i has no effect.
- R7: A new timeout code written while the watchdog runs does not change the current countdown. It is used at the next service reload.
- R8: Interrupt-control bit 15 enables the early warning and bits 7:0 hold a lead time P. Bit 14 (irq_o) sets (T-P)*PRESCALE cycles after the start. Writing 1 to bit 14 clears it, but a set in the same cycle wins over the clear.
- R9: Writing control bit 4 = 0 raises int_rst_o for exactly SRS_HOLD low-frequency ticks, after which bit 4 reads 1 again. Writes of 1 to bit 4 during that window are ignored.
- R10: Control bit 5 = 0 drives ext_rst_no low in the cycle after the write, and writing 1 releases it.
- R11: Reset status bit 1 is set by a timeout and bit 0 by a software reset request. Each event clears the other bit. The bits survive rst_ni and are cleared only by por_ni.
- R12: After rst_ni the power-down counter pulses ext_rst_no low for exactly one cycle, PDN_STEPS*PRESCALE cycles after release, and then reads 0 in bit 0 of the miscellaneous register. Writing 0 to that bit first disarms it, and writing 1 never re-arms it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low power-on reset for the reset-cause record |
| lf_tick_i | input | 1 | One-cycle strobe per low-frequency clock period |
| low_power_i | input | 1 | High while the system is in low-power mode |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| int_rst_o | output | 1 | Internal chip-reset request, active high |
| ext_rst_no | output | 1 | External reset line, active low |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
Two functions can fall in the same cycle: the early-warning status setting on a countdown step, and a software write-1-to-clear on that status bit. The bench schedules the clearing write so that it lands exactly on the clock edge where the lead-time step occurs. That edge is computed from the programmed timeout and lead time. The bench then checks that irq_o is still high, so the set has won. A clearing write issued one cycle later must drop irq_o.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // register byte offsets
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SVC  = 4'h2;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_IRQ  = 4'h6;
    localparam logic [3:0] OFS_MISC = 4'h8;

    // service key pair, must arrive in this order
    localparam logic [15:0] SVC_KEY_FIRST  = 16'h5555;
    localparam logic [15:0] SVC_KEY_SECOND = 16'hAAAA;

    // control field positions
    localparam int CTRL_SUSP  = 0;
    localparam int CTRL_EN    = 2;
    localparam int CTRL_ACT   = 3;
    localparam int CTRL_SWRST = 4;
    localparam int CTRL_XRST  = 5;
    localparam int CTRL_TMO_L = 8;

    // interrupt control field positions
    localparam int IRQ_STS = 14;
    localparam int IRQ_EN  = 15;

    localparam int TMO_W = 8;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_SOFT  = 2'b01,
        CAUSE_TMO   = 2'b10
    } cause_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 16384
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clr_i,
    output logic step_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        step_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                step_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
    import wdog_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        reload_o
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d  = armed_q;
        reload_o = 1'b0;
        if (wr_i) begin
            reload_o = armed_q && (data_i == SVC_KEY_SECOND);
            armed_d  = (data_i == SVC_KEY_FIRST);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= armed_d;
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    input  logic         run_i,
    input  logic [W-1:0] lead_i,
    output logic         lead_hit_o,
    output logic         expire_o,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] nxt;

    assign nxt     = cnt_q - W'(1);
    assign count_o = cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        lead_hit_o = 1'b0;
        expire_o   = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (step_i && run_i) begin
            if (cnt_q == '0) begin
                expire_o = 1'b1;
            end else begin
                cnt_d      = nxt;
                lead_hit_o = (nxt == lead_i);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRESCALE  = 16384,
    parameter int PDN_STEPS = 32,
    parameter int SRS_HOLD  = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        por_ni,
    input  logic        lf_tick_i,
    input  logic        low_power_i,
    input  logic        bus_we_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic        int_rst_o,
    output logic        ext_rst_no,
    output logic        irq_o
);
    localparam int PDN_W  = $clog2(PDN_STEPS + 1);
    localparam int HOLD_W = $clog2(SRS_HOLD + 1);
    localparam int NUM_PS = 2;   // 0: watchdog phase, 1: power-down counter

    typedef struct packed {
        logic [TMO_W-1:0]  tmo;
        logic              xrst;
        logic              swrst;
        logic              act;
        logic              en;
        logic              susp;
        logic              susp_lock;
        logic              irq_en;
        logic              irq_sts;
        logic [TMO_W-1:0]  lead;
        logic              pdn_en;
        logic              pdn_pulse;
        logic [PDN_W-1:0]  pdn_cnt;
        logic [HOLD_W-1:0] hold_cnt;
        logic              fired;
    } regs_t;

    regs_t       r_d, r_q;
    logic [1:0]  cause_d, cause_q;

    logic wr_ctrl, wr_svc, wr_irq, wr_misc;
    logic svc_reload, en_rise, cd_load, cd_run;
    logic [TMO_W-1:0] cd_load_val;
    logic cd_lead_hit, cd_expire;
    logic [TMO_W-1:0] cd_count;
    logic [NUM_PS-1:0] ps_clr, ps_step;

    // ---------------- decode ----------------
    always_comb begin
        wr_ctrl = bus_we_i && (bus_addr_i == OFS_CTRL);
        wr_svc  = bus_we_i && (bus_addr_i == OFS_SVC);
        wr_irq  = bus_we_i && (bus_addr_i == OFS_IRQ);
        wr_misc = bus_we_i && (bus_addr_i == OFS_MISC);
    end

    wdog_svc_seq u_svc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_svc),
        .data_i   (bus_wdata_i),
        .reload_o (svc_reload)
    );

    always_comb begin
        en_rise     = wr_ctrl && bus_wdata_i[CTRL_EN] && !r_q.en;
        cd_load     = !r_q.fired && (en_rise || (svc_reload && r_q.en));
        cd_load_val = en_rise ? bus_wdata_i[CTRL_TMO_L +: TMO_W] : r_q.tmo;
        cd_run      = r_q.en && !r_q.fired && !(low_power_i && r_q.susp);
    end

    assign ps_clr = {1'b0, cd_load};

    for (genvar g = 0; g < NUM_PS; g++) begin : g_ps
        wdog_prescaler #(.DIV(PRESCALE)) u_ps (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .tick_i (lf_tick_i),
            .clr_i  (ps_clr[g]),
            .step_o (ps_step[g])
        );
    end

    wdog_countdown #(.W(TMO_W)) u_cd (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cd_load),
        .load_val_i (cd_load_val),
        .step_i     (ps_step[0]),
        .run_i      (cd_run),
        .lead_i     (r_q.lead),
        .lead_hit_o (cd_lead_hit),
        .expire_o   (cd_expire),
        .count_o    (cd_count)
    );

    // ---------------- next state ----------------
    always_comb begin
        r_d     = r_q;
        cause_d = cause_q;
        r_d.pdn_pulse = 1'b0;

        if (cd_expire) begin
            r_d.fired = 1'b1;
            cause_d   = CAUSE_TMO;
        end

        if (wr_ctrl) begin
            r_d.tmo  = bus_wdata_i[CTRL_TMO_L +: TMO_W];
            r_d.xrst = bus_wdata_i[CTRL_XRST];
            r_d.act  = r_q.act | bus_wdata_i[CTRL_ACT];
            r_d.en   = r_q.en  | bus_wdata_i[CTRL_EN];
            if (!r_q.susp_lock) begin
                r_d.susp = bus_wdata_i[CTRL_SUSP];
            end
            r_d.susp_lock = 1'b1;
            if (r_q.swrst && !bus_wdata_i[CTRL_SWRST]) begin
                r_d.swrst    = 1'b0;
                r_d.hold_cnt = '0;
                cause_d      = CAUSE_SOFT;
            end
        end

        // software reset request hold window
        if (!r_q.swrst && lf_tick_i) begin
            if (r_q.hold_cnt == HOLD_W'(SRS_HOLD - 1)) begin
                r_d.swrst    = 1'b1;
                r_d.hold_cnt = '0;
            end else begin
                r_d.hold_cnt = r_q.hold_cnt + 1'b1;
            end
        end

        if (wr_irq) begin
            r_d.irq_en = bus_wdata_i[IRQ_EN];
            r_d.lead   = bus_wdata_i[TMO_W-1:0];
            if (bus_wdata_i[IRQ_STS]) begin
                r_d.irq_sts = 1'b0;
            end
        end
        if (cd_lead_hit && r_q.irq_en) begin
            r_d.irq_sts = 1'b1;          // set beats clear
        end

        if (r_q.pdn_en && ps_step[1]) begin
            if (r_q.pdn_cnt == '0) begin
                r_d.pdn_pulse = 1'b1;
                r_d.pdn_en    = 1'b0;
            end else begin
                r_d.pdn_cnt = r_q.pdn_cnt - 1'b1;
            end
        end
        if (wr_misc && !bus_wdata_i[0]) begin
            r_d.pdn_en = 1'b0;
        end
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q         <= '0;
            r_q.xrst    <= 1'b1;
            r_q.swrst   <= 1'b1;
            r_q.pdn_en  <= 1'b1;
            r_q.pdn_cnt <= PDN_W'(PDN_STEPS - 1);
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) cause_q <= CAUSE_NONE;
        else         cause_q <= cause_d;
    end

    // ---------------- outputs ----------------
    assign int_rst_o  = (r_q.fired && !r_q.act) || !r_q.swrst;
    assign ext_rst_no = !((r_q.fired && r_q.act) || !r_q.xrst || r_q.pdn_pulse);
    assign irq_o      = r_q.irq_sts;

    always_comb begin
        unique case (bus_addr_i)
            OFS_CTRL: bus_rdata_o = {r_q.tmo, 2'b00, r_q.xrst, r_q.swrst,
                                     r_q.act, r_q.en, 1'b0, r_q.susp};
            OFS_STAT: bus_rdata_o = {14'd0, cause_q};
            OFS_IRQ:  bus_rdata_o = {r_q.irq_en, r_q.irq_sts, 6'd0, r_q.lead};
            OFS_MISC: bus_rdata_o = {15'd0, r_q.pdn_en};
            default:  bus_rdata_o = 16'd0;
        endcase
    end

endmodule

// File: rtl/wdog_checks.sv
module wdog_checks #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         por_ni,
    input logic         en,
    input logic         act,
    input logic         fired,
    input logic         swrst,
    input logic         pdn_pulse,
    input logic         irq_sts,
    input logic         irq_en,
    input logic [1:0]   cause,
    input logic [W-1:0] count,
    input logic         int_rst_o
);
    a_r5_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |=> en);

    a_r5_action_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act |=> act);

    a_r2_expiry_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fired |=> fired);

    a_r2_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fired |=> $stable(count));

    a_r12_pdn_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdn_pulse |=> !pdn_pulse);

    a_r8_warning_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_sts) |-> $past(irq_en));

    a_r11_single_cause: assert property (@(posedge clk_i) disable iff (!por_ni)
        $onehot0(cause));

    a_r9_soft_request_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !swrst |-> int_rst_o);
endmodule

bind wdog_core wdog_checks #(.W(wdog_pkg::TMO_W)) u_checks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_ni    (por_ni),
    .en        (r_q.en),
    .act       (r_q.act),
    .fired     (r_q.fired),
    .swrst     (r_q.swrst),
    .pdn_pulse (r_q.pdn_pulse),
    .irq_sts   (r_q.irq_sts),
    .irq_en    (r_q.irq_en),
    .cause     (cause_q),
    .count     (cd_count),
    .int_rst_o (int_rst_o)
);

// File: tb/test_wdog_core.sv
module test_wdog_core;
    localparam int PS   = 4;
    localparam int PDN  = 3;
    localparam int HOLD = 3;

    localparam logic [3:0] A_CTRL = 4'h0, A_SVC = 4'h2, A_STAT = 4'h4,
                           A_IRQ = 4'h6, A_MISC = 4'h8;
    localparam int K_IRQ = 1, K_INT = 2, K_EXT = 3;

    logic        clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
    logic        lf_tick = 1'b1, low_pwr = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        int_rst, ext_rst_n, irq;

    wdog_core #(.PRESCALE(PS), .PDN_STEPS(PDN), .SRS_HOLD(HOLD)) i_wdog_core (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .lf_tick_i(lf_tick),
        .low_power_i(low_pwr), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .int_rst_o(int_rst),
        .ext_rst_no(ext_rst_n), .irq_o(irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_chk = 0, n_fail = 0, last_cyc = 0;
    bit  finished = 0;

    typedef struct { int kind; int at; string req; } ev_t;
    ev_t exp_q[$];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, int at, string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic take(int kind);
        ev_t e;
        if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL unexpected output event: actual kind %0d at cycle %0d expected none", kind, cyc);
        end else begin
            e = exp_q.pop_front();
            check({e.req, " event kind"}, kind, e.kind);
            check({e.req, " event cycle"}, cyc, e.at);
        end
    endtask

    // monitor: output edges popped against the scoreboard
    logic p_irq = 1'b0, p_int = 1'b0, p_ext = 1'b1;
    always @(negedge clk) begin
        if (rst_n && por_n) begin
            if (irq && !p_irq)       take(K_IRQ);
            if (int_rst && !p_int)   take(K_INT);
            if (!ext_rst_n && p_ext) take(K_EXT);
        end
        p_irq = irq; p_int = int_rst; p_ext = ext_rst_n;
    end

    task automatic drive_wr(logic [3:0] a, logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
        last_cyc = cyc;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        drive_wr(a, d);
    endtask

    task automatic wr_at(int c, logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        while (cyc < c - 1) @(negedge clk);
        check("write slot reachable", cyc, c - 1);
        drive_wr(a, d);
    endtask

    task automatic rchk(string req, logic [3:0] a, int exp);
        @(negedge clk);
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic wait_cyc(int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(A_MISC, 16'h0000);          // disarm power-down counter
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int r0, r1;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk); #1; r0 = cyc;

        // R1 reset state
        check("R1 int_rst_o", int_rst, 0);
        check("R1 ext_rst_no", ext_rst_n, 1);
        check("R1 irq_o", irq, 0);
        rchk("R1 control", A_CTRL, 16'h0030);
        rchk("R1 irq control", A_IRQ, 16'h0000);
        rchk("R1 misc", A_MISC, 16'h0001);
        rchk("R1 status", A_STAT, 16'h0000);
        rchk("R1 service", A_SVC, 16'h0000);

        // R12 power-down pulse, one cycle, then disarmed
        expect_ev(K_EXT, r0 + PS*PDN - 1, "R12 pdn pulse");
        wait_cyc(r0 + PS*PDN + 1);
        check("R12 pulse is one cycle", ext_rst_n, 1);
        rchk("R12 misc after expiry", A_MISC, 0);
        wr(A_MISC, 16'h0001);
        rchk("R12 no re-arm", A_MISC, 0);
        sys_reset();
        wait_cyc(last_cyc + PS*PDN + 4);
        rchk("R12 disarmed misc", A_MISC, 0);

        // R2 internal timeout
        wr(A_CTRL, 16'h0334);
        expect_ev(K_INT, last_cyc + PS*4, "R2 timeout");
        wait_cyc(last_cyc + PS*4 + 2);
        check("R2 int_rst held", int_rst, 1);
        check("R2 ext stays high", ext_rst_n, 1);
        rchk("R11 timeout cause", A_STAT, 16'h0002);
        sys_reset();
        rchk("R11 cause survives rst_ni", A_STAT, 16'h0002);
        check("R2 int_rst cleared by reset", int_rst, 0);

        // R3 external action
        wr(A_CTRL, 16'h033C);
        expect_ev(K_EXT, last_cyc + PS*4, "R3 external timeout");
        wait_cyc(last_cyc + PS*4 + 2);
        check("R3 int_rst stays low", int_rst, 0);
        check("R3 ext held low", ext_rst_n, 0);
        sys_reset();

        // R4 good service sequence
        wr(A_CTRL, 16'h0334); r0 = last_cyc;
        wait_cyc(r0 + 10);
        wr(A_SVC, 16'h5555);
        wr(A_SVC, 16'hAAAA); r1 = last_cyc;
        expect_ev(K_INT, r1 + PS*4, "R4 reload");
        wait_cyc(r1 + PS*4 + 2);
        sys_reset();

        // R4 wrong order / interrupted sequence
        wr(A_CTRL, 16'h0334); r0 = last_cyc;
        wr(A_SVC, 16'hAAAA);
        wr(A_SVC, 16'h5555);
        wr(A_SVC, 16'h1234);
        wr(A_SVC, 16'hAAAA);
        expect_ev(K_INT, r0 + PS*4, "R4 bad sequence ignored");
        wait_cyc(r0 + PS*4 + 2);
        sys_reset();

        // R5 sticky enable and action
        wr(A_CTRL, 16'h033C); r0 = last_cyc;
        wr(A_CTRL, 16'h0330);
        rchk("R5 sticky bits", A_CTRL, 16'h033C);
        expect_ev(K_EXT, r0 + PS*4, "R5 still running");
        wait_cyc(r0 + PS*4 + 2);
        sys_reset();

        // R7 new timeout used at next reload
        wr(A_CTRL, 16'h0334); r0 = last_cyc;
        wr(A_CTRL, 16'h0A34);
        rchk("R7 timeout field", A_CTRL, 16'h0A34);
        wait_cyc(r0 + 8);
        wr(A_SVC, 16'h5555);
        wr(A_SVC, 16'hAAAA); r1 = last_cyc;
        expect_ev(K_INT, r1 + PS*11, "R7 new timeout");
        wait_cyc(r1 + PS*11 + 2);
        sys_reset();

        // R6 write-once suspend bit and low-power freeze
        low_pwr = 1'b1;
        wr(A_CTRL, 16'h0331);
        wr(A_CTRL, 16'h0334);
        rchk("R6 suspend bit locked", A_CTRL, 16'h0335);
        wait_cyc(last_cyc + PS*10);
        check("R6 frozen no reset", int_rst, 0);
        sys_reset();
        wr(A_CTRL, 16'h0334);
        expect_ev(K_INT, last_cyc + PS*4, "R6 low power ignored without suspend");
        wait_cyc(last_cyc + PS*4 + 2);
        low_pwr = 1'b0;
        sys_reset();

        // R8 early warning, set wins over same-cycle clear
        wr(A_IRQ, 16'h8001);
        wr(A_CTRL, 16'h0534); r0 = last_cyc;
        expect_ev(K_IRQ, r0 + PS*4, "R8 warning");
        expect_ev(K_INT, r0 + PS*6, "R8 timeout");
        wr_at(r0 + PS*4, A_IRQ, 16'hC001);
        check("R8 set wins over clear", irq, 1);
        wr(A_IRQ, 16'hC001);
        check("R8 write-1 clears", irq, 0);
        rchk("R8 irq control", A_IRQ, 16'h8001);
        wait_cyc(r0 + PS*6 + 2);
        sys_reset();

        // R9 software reset hold
        wr(A_CTRL, 16'h0020); r0 = last_cyc;
        expect_ev(K_INT, r0, "R9 soft reset");
        wr(A_CTRL, 16'h0030);
        wait_cyc(r0 + HOLD - 1);
        check("R9 held", int_rst, 1);
        wait_cyc(r0 + HOLD);
        check("R9 released", int_rst, 0);
        rchk("R9 bit reads 1", A_CTRL, 16'h0030);
        rchk("R11 soft cause", A_STAT, 16'h0001);

        // R10 external line drive
        wr(A_CTRL, 16'h0010);
        expect_ev(K_EXT, last_cyc, "R10 drive low");
        wr(A_CTRL, 16'h0030);
        check("R10 release", ext_rst_n, 1);

        // R11 power-on clears cause
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
        wr(A_MISC, 16'h0000);
        rchk("R11 cleared by por", A_STAT, 16'h0000);

        repeat (4) @(negedge clk);
        check("all expected events seen", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule